// File: doc/BRIEF.md
# SDRAM Row Activation Rule Checker

This block sits on the controller side of an SDRAM interface and judges each command before it goes out. Every clock cycle it receives one command with a bank number and a row address. In the same cycle it reports whether that command obeys the row-activation rules, and if it does not, which rule it breaks. It keeps track of whether each of the four banks has an open row and, if so, which row. It also runs the delay timers that start on each activation.

Timing limits are given as parameters in picoseconds, together with the clock period. At elaboration, each limit is turned into a clock count by dividing by the period and rounding up. For example, 20000 ps at a 7500 ps period becomes 3 clocks.

Each bank is a two-state machine. In CLOSED, an accepted ACTIVE takes the ACTIVATE transition to OPEN. In OPEN, a PRECHARGE takes the PRECHARGE transition back to CLOSED. Every other command leaves the state where it is. A separate timer that covers all banks enforces the spacing between activations of different banks.

Top module: `sdram_act_checker`

## Requirements
- R1: Each limit converts to clocks as ceil(limit_ps / TCK_PS). The defaults give 3 clocks for activate-to-access, 9 clocks for activate-to-activate on one bank, and 2 clocks for activate-to-activate across banks.
- R2: After reset every bank is closed and every timer has expired. A NOP is legal, any ACTIVE is accepted at once, and a READ to any bank is rejected as closed.
- R3: A READ (cmd 2) or WRITE (cmd 3) to the open row of a bank, issued n cycles after that bank's ACTIVE, is illegal with code 1 when n < 3 and legal when n >= 3.
- R4: A row stays open and can be accessed any number of times until a PRECHARGE (cmd 4) reaches its bank. After that, accesses to the bank are refused.
- R5: An ACTIVE (cmd 1) to a bank that already has an open row is illegal with code 4.
- R6: An ACTIVE to a closed bank fewer than 9 cycles after that bank's previous accepted ACTIVE is illegal with code 2. At exactly 9 cycles it is legal.
- R7: An ACTIVE to a bank other than the most recently activated one, issued fewer than 2 cycles after that activation, is illegal with code 3. An ACTIVE to another bank is otherwise allowed even while some bank is open.
- R8: A READ or WRITE to a closed bank is illegal with code 5. A READ or WRITE to an open bank at a row other than its open row is illegal with code 6.
- R9: A rejected command changes neither bank state, open rows nor timers.
- R10: A PRECHARGE to a closed bank is legal and has no effect on any bank.
- R11: The output legal_o is 1 exactly when err_o is 0. For ACTIVE, the checks apply in the order open (4), then tRC (2), then tRRD (3). For READ/WRITE, the order is closed (5), then row mismatch (6), then tRCD (1). NOP (cmd 0) and the unused codes 5 to 7 are always legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE |
| bank_i | input | BANK_W | Target bank |
| row_i | input | ROW_W | Row address (used by ACTIVE, READ, WRITE) |
| legal_o | output | 1 | Command obeys all rules |
| err_o | output | 3 | Violated rule: 0 none, 1 tRCD, 2 tRC, 3 tRRD, 4 bank open, 5 bank closed, 6 row mismatch |

## Verification
The verdict on a command is combinational from the command and the registered state, so it is due in the same cycle the command is presented. Accepting a command updates state at the next rising edge, and the command after that is the first to see the new state. The bench drives inputs at the falling edge and samples a quarter period later, before the edge that commits them. Each expected verdict in the table was worked out by counting cycles from the accepted ACTIVE it depends on, with the counted distance n recorded beside it.

// File: rtl/sdram_act_pkg.sv
package sdram_act_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        ERR_NONE   = 3'd0,
        ERR_TRCD   = 3'd1,
        ERR_TRC    = 3'd2,
        ERR_TRRD   = 3'd3,
        ERR_OPEN   = 3'd4,
        ERR_CLOSED = 3'd5,
        ERR_ROW    = 3'd6
    } err_e;

    typedef enum logic {
        B_CLOSED = 1'b0,
        B_OPEN   = 1'b1
    } bank_state_e;

    // ceil(t / tck) in whole clocks
    function automatic int ps_to_clk(input int t_ps, input int tck_ps);
        return (t_ps + tck_ps - 1) / tck_ps;
    endfunction

endpackage

// File: rtl/act_bank_fsm.sv
module act_bank_fsm
    import sdram_act_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int NRCD  = 3,
    parameter int NRC   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_fire,
    input  logic             pre_fire,
    input  logic [ROW_W-1:0] row_i,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row,
    output logic             rcd_ok,
    output logic             rc_ok
);

    localparam int RCD_W = $clog2(NRCD + 1);
    localparam int RC_W  = $clog2(NRC + 1);
    localparam logic [RCD_W-1:0] RCD_LOAD = RCD_W'(NRCD - 1);
    localparam logic [RC_W-1:0]  RC_LOAD  = RC_W'(NRC - 1);

    bank_state_e      state_q, state_d;
    logic [ROW_W-1:0] row_q;
    logic [RCD_W-1:0] rcd_q;
    logic [RC_W-1:0]  rc_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            B_CLOSED: if (act_fire) state_d = B_OPEN;
            B_OPEN:   if (pre_fire) state_d = B_CLOSED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= B_CLOSED;
        else        state_q <= state_d;
    end

    // open row and the two per-bank timers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            rcd_q <= '0;
            rc_q  <= '0;
        end else begin
            if (act_fire) row_q <= row_i;
            if (act_fire)       rcd_q <= RCD_LOAD;
            else if (rcd_q != 0) rcd_q <= rcd_q - 1'b1;
            if (act_fire)       rc_q <= RC_LOAD;
            else if (rc_q != 0) rc_q <= rc_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        is_open  = (state_q == B_OPEN);
        open_row = row_q;
        rcd_ok   = (rcd_q == '0);
        rc_ok    = (rc_q == '0);
    end

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |=> is_open); // R4
    AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        pre_fire |=> !is_open); // R4
    AST_ACT_ONLY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |-> (!is_open && rc_ok)); // R5
    AST_RCD_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (act_fire && (NRCD > 1)) |=> !rcd_ok); // R3
    AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_open && !act_fire) |=> $stable(open_row)); // R4

endmodule

// File: rtl/act_rrd_timer.sv
module act_rrd_timer #(
    parameter int BANK_W = 2,
    parameter int NRRD   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_fire,
    input  logic [BANK_W-1:0] act_bank,
    input  logic [BANK_W-1:0] req_bank,
    output logic              rrd_block
);

    localparam int RRD_W = $clog2(NRRD + 1);
    localparam logic [RRD_W-1:0] RRD_LOAD = RRD_W'(NRRD - 1);

    logic [RRD_W-1:0]  cnt_q;
    logic [BANK_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= '0;
        end else if (act_fire) begin
            cnt_q  <= RRD_LOAD;
            last_q <= act_bank;
        end else if (cnt_q != 0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb rrd_block = (cnt_q != '0) && (req_bank != last_q);

    AST_RRD_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (act_fire && (NRRD > 1)) |=> (cnt_q != '0)); // R7
    AST_RRD_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_fire && ($past(cnt_q) != '0) && $past(rst_n)) |-> (cnt_q == $past(cnt_q) - 1'b1)); // R7

endmodule

// File: rtl/sdram_act_checker.sv
module sdram_act_checker
    import sdram_act_pkg::*;
#(
    parameter int ROW_W   = 13,
    parameter int BANK_W  = 2,
    parameter int TCK_PS  = 7500,
    parameter int TRCD_PS = 20000,
    parameter int TRC_PS  = 65000,
    parameter int TRRD_PS = 15000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ROW_W-1:0]  row_i,
    output logic              legal_o,
    output logic [2:0]        err_o
);

    localparam int NBANK = 1 << BANK_W;
    localparam int NRCD  = ps_to_clk(TRCD_PS, TCK_PS);
    localparam int NRC   = ps_to_clk(TRC_PS, TCK_PS);
    localparam int NRRD  = ps_to_clk(TRRD_PS, TCK_PS);

    cmd_e             cmd;
    err_e             err;
    logic [NBANK-1:0] act_fire;
    logic [NBANK-1:0] pre_fire;
    logic [NBANK-1:0] bank_open;
    logic [NBANK-1:0] bank_rcd_ok;
    logic [NBANK-1:0] bank_rc_ok;
    logic [ROW_W-1:0] bank_row [NBANK];
    logic             rrd_block;
    logic             act_any;

    always_comb cmd = cmd_e'(cmd_i);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        localparam logic [BANK_W-1:0] BID = BANK_W'(g);
        assign act_fire[g] = legal_o && (cmd == CMD_ACT) && (bank_i == BID);
        assign pre_fire[g] = (cmd == CMD_PRE) && (bank_i == BID);
        act_bank_fsm #(
            .ROW_W (ROW_W),
            .NRCD  (NRCD),
            .NRC   (NRC)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_fire (act_fire[g]),
            .pre_fire (pre_fire[g]),
            .row_i    (row_i),
            .is_open  (bank_open[g]),
            .open_row (bank_row[g]),
            .rcd_ok   (bank_rcd_ok[g]),
            .rc_ok    (bank_rc_ok[g])
        );
    end

    assign act_any = |act_fire;

    act_rrd_timer #(
        .BANK_W (BANK_W),
        .NRRD   (NRRD)
    ) u_rrd (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_fire  (act_any),
        .act_bank  (bank_i),
        .req_bank  (bank_i),
        .rrd_block (rrd_block)
    );

    // rule evaluation, in priority order per command
    always_comb begin
        err = ERR_NONE;
        case (cmd)
            CMD_ACT: begin
                if (bank_open[bank_i])        err = ERR_OPEN;
                else if (!bank_rc_ok[bank_i]) err = ERR_TRC;
                else if (rrd_block)           err = ERR_TRRD;
            end
            CMD_RD, CMD_WR: begin
                if (!bank_open[bank_i])                err = ERR_CLOSED;
                else if (bank_row[bank_i] != row_i)    err = ERR_ROW;
                else if (!bank_rcd_ok[bank_i])         err = ERR_TRCD;
            end
            default: err = ERR_NONE;
        endcase
    end

    always_comb begin
        legal_o = (err == ERR_NONE);
        err_o   = err;
    end

    AST_RW_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (((cmd_i == 3'd2) || (cmd_i == 3'd3)) && !bank_open[bank_i]) |-> (err_o == 3'd5)); // R8
    AST_REJECT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        !legal_o |=> $stable(bank_open)); // R9
    AST_PRE_ALWAYS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd4) |-> legal_o); // R10
    AST_ONE_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_fire)); // R11

endmodule

// File: tb/sdram_act_checker_test.sv
module sdram_act_checker_test;

    localparam int CLK_PERIOD = 10;
    localparam int ROW_W  = 13;
    localparam int BANK_W = 2;
    localparam int NV     = 21;

    // {req[20:17], cmd[16:14], bank[13:12], row[11:4], legal[3], err[2:0]}
    // n = cycles since the relevant accepted ACTIVE (tRCD 3, tRC 9, tRRD 2)
    localparam logic [20:0] VEC [NV] = '{
        {4'd8,  3'd2, 2'd0, 8'd5, 1'b0, 3'd5},  // c0  R8 RD closed bank
        {4'd2,  3'd1, 2'd0, 8'd5, 1'b1, 3'd0},  // c1  R2 ACT b0 right after reset
        {4'd7,  3'd1, 2'd1, 8'd7, 1'b0, 3'd3},  // c2  R7 ACT b1 n=1
        {4'd3,  3'd2, 2'd0, 8'd5, 1'b0, 3'd1},  // c3  R3 RD b0 n=2
        {4'd3,  3'd2, 2'd0, 8'd5, 1'b1, 3'd0},  // c4  R3 RD b0 n=3
        {4'd7,  3'd1, 2'd1, 8'd7, 1'b1, 3'd0},  // c5  R7 ACT b1 while b0 open
        {4'd8,  3'd3, 2'd0, 8'd6, 1'b0, 3'd6},  // c6  R8 WR b0 wrong row
        {4'd5,  3'd1, 2'd0, 8'd2, 1'b0, 3'd4},  // c7  R5 ACT b0 already open
        {4'd9,  3'd3, 2'd0, 8'd5, 1'b1, 3'd0},  // c8  R9 row 5 kept after rejected ACT
        {4'd4,  3'd2, 2'd1, 8'd7, 1'b1, 3'd0},  // c9  R4 RD b1 n=4
        {4'd4,  3'd4, 2'd1, 8'd0, 1'b1, 3'd0},  // c10 R4 PRE b1
        {4'd6,  3'd1, 2'd1, 8'd3, 1'b0, 3'd2},  // c11 R6 ACT b1 n=6
        {4'd9,  3'd2, 2'd1, 8'd7, 1'b0, 3'd5},  // c12 R9 rejected ACT left b1 closed
        {4'd10, 3'd4, 2'd3, 8'd0, 1'b1, 3'd0},  // c13 R10 PRE closed b3
        {4'd6,  3'd1, 2'd1, 8'd3, 1'b1, 3'd0},  // c14 R6 ACT b1 n=9
        {4'd7,  3'd1, 2'd2, 8'd0, 1'b0, 3'd3},  // c15 R7 ACT b2 n=1
        {4'd7,  3'd1, 2'd2, 8'd0, 1'b1, 3'd0},  // c16 R7 ACT b2 n=2
        {4'd10, 3'd2, 2'd3, 8'd0, 1'b0, 3'd5},  // c17 R10 b3 still closed
        {4'd11, 3'd0, 2'd0, 8'd0, 1'b1, 3'd0},  // c18 R11 NOP legal
        {4'd1,  3'd3, 2'd2, 8'd0, 1'b1, 3'd0},  // c19 R1 WR b2 n=3
        {4'd4,  3'd3, 2'd1, 8'd3, 1'b1, 3'd0}   // c20 R4 WR b1 n=6
    };

    logic              clk;
    logic              rst_n;
    logic [2:0]        cmd_i;
    logic [BANK_W-1:0] bank_i;
    logic [ROW_W-1:0]  row_i;
    logic              legal_o;
    logic [2:0]        err_o;

    int  n_vec;
    int  n_bad;
    bit  done;

    sdram_act_checker #(.ROW_W(ROW_W), .BANK_W(BANK_W)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_i   (cmd_i),
        .bank_i  (bank_i),
        .row_i   (row_i),
        .legal_o (legal_o),
        .err_o   (err_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic exp_l, input logic [2:0] exp_e);
        n_vec++;
        if (legal_o !== exp_l || err_o !== exp_e) begin
            n_bad++;
            $display("FAIL %s: got legal=%0b err=%0d, expected legal=%0b err=%0d",
                     req, legal_o, err_o, exp_l, exp_e);
        end
    endtask

    task automatic drive(input logic [2:0] c, input logic [BANK_W-1:0] b, input logic [ROW_W-1:0] r);
        @(negedge clk);
        cmd_i  = c;
        bank_i = b;
        row_i  = r;
        #(CLK_PERIOD/4);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_i = 3'd0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        n_vec = 0;
        n_bad = 0;
        done  = 1'b0;
        rst_n = 1'b0;
        cmd_i = 3'd0;
        bank_i = '0;
        row_i  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #(CLK_PERIOD/4);
        check("R2", 1'b1, 3'd0);  // reset state: NOP legal

        for (int i = 0; i < NV; i++) begin
            logic [20:0] v;
            v = VEC[i];
            drive(v[16:14], v[13:12], ROW_W'(v[11:4]));
            check($sformatf("R%0d vec %0d", v[20:17], i), v[3], v[2:0]);
        end

        // directed: reset right after an activation clears state and timers
        drive(3'd1, 2'd3, ROW_W'(9));
        check("R7", 1'b1, 3'd0);
        do_reset();
        #(CLK_PERIOD/4);
        cmd_i = 3'd2; bank_i = 2'd2; row_i = '0;
        #1;
        check("R2", 1'b0, 3'd5);       // b2 was open before reset
        drive(3'd1, 2'd3, ROW_W'(9));
        check("R2", 1'b1, 3'd0);       // tRC of b3 cleared by reset
        drive(3'd1, 2'd3, ROW_W'(9));
        check("R11", 1'b0, 3'd4);      // open beats tRC
        drive(3'd2, 2'd3, ROW_W'(8));
        check("R11", 1'b0, 3'd6);      // row mismatch beats tRCD (n=2)
        drive(3'd1, 2'd0, ROW_W'(1));
        check("R7", 1'b1, 3'd0);       // other bank n=3
        drive(3'd5, 2'd0, ROW_W'(1));
        check("R11", 1'b1, 3'd0);      // unused code is a no-op

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule